// File: doc/BRIEF.md
# Slot-Table Crossbar Arbiter

This block decides which of several requesters may use one shared downstream port. Each direction (read and write) has its own cyclic table of time slots. Every slot names the requester that owns it, and a pointer walks the table in order. A requester's share of the port is therefore set by how many slots it owns. Its worst-case wait is set by where those slots sit in the cycle: spread-out slots give short gaps, and bunched slots give long ones.

When the arbiter is idle, it searches the table from the pointer for the first slot whose owner is requesting. Slots whose owners are quiet are skipped in the same cycle. The winner receives a registered one-hot grant and keeps it until that channel's completion strobe. The pointer then moves one slot past the slot that was served. Both tables can be rewritten at run time through a small write port. A new entry is consulted only at the next search, never against a grant already issued. A requester left without any slot is never served.

Top module: `slot_xbar_arb`

## Requirements
- R1: During and after reset both grant outputs are zero, and in both tables slot s is owned by requester s mod NUM_REQ (16 slots, 8 requesters: two slots each, interleaved).
- R2: A grant vector is zero or one-hot. A grant bit rises only for a requester whose request was high at the clock edge that issued it, and it appears on the edge after that request was sampled.
- R3: Once issued, a grant stays unchanged, even if the request falls, until the same channel's done input is sampled high. The grant is zero from the following edge.
- R4: After done, the next search starts at the served slot plus one (modulo 16). The first slot in cyclic order whose owner requests wins.
- R5: Slots whose owners are not requesting are skipped within one search, so a lone requester is granted one cycle after it requests, wherever its slot lies.
- R6: The read and write channels arbitrate concurrently and independently. A table write with cfg_chan=0 changes only the read table, and with cfg_chan=1 only the write table.
- R7: A requester that owns no slot in a channel's table is never granted on that channel.
- R8: Table writes (cfg_we with cfg_slot and cfg_owner) during a grant leave that grant unchanged and are used by the next search.
- R9: A done input sampled while its channel holds no grant has no effect, including on the pointer.
- R10: With every requester asserting continuously, over one full pass of 16 grants each requester is served exactly as many times as it owns slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | NUM_REQ | Read request per requester |
| wr_req | input | NUM_REQ | Write request per requester |
| rd_done | input | 1 | Read transaction complete |
| wr_done | input | 1 | Write transaction complete |
| cfg_we | input | 1 | Slot-table write strobe |
| cfg_chan | input | 1 | Table select: 0 read, 1 write |
| cfg_slot | input | $clog2(NUM_SLOTS) | Slot index to write |
| cfg_owner | input | $clog2(NUM_REQ) | Requester index stored in the slot |
| rd_gnt | output | NUM_REQ | One-hot read grant (registered) |
| wr_gnt | output | NUM_REQ | One-hot write grant (registered) |

## Verification
A corrupted pointer shows up at the very next search as a grant to the wrong requester whenever several requesters compete. A lost busy flag shows up at once as a grant that changes or drops before its done. A table entry held in the wrong place only shows when that slot is reached. For that reason the bench drives full passes of all-requesting traffic and compares both grant vectors against a behavioural model on every clock, so a divergence is reported in the cycle it first reaches the ports.

// File: rtl/slotarb_pkg.sv
package slotarb_pkg;
  typedef enum logic {
    CH_RD = 1'b0,
    CH_WR = 1'b1
  } chan_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_REQ   = 8,
  parameter int NUM_SLOTS = 16,
  parameter logic CHAN_ID = 1'b0,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int RW = $clog2(NUM_REQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    chan,
  input  logic [SW-1:0]           slot,
  input  logic [RW-1:0]           owner,
  output logic [NUM_SLOTS*RW-1:0] owners
);
  logic [RW-1:0] tbl [NUM_SLOTS];

  // Reset fills the table round-robin so ownership is interleaved.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) tbl[s] <= RW'(s % NUM_REQ);
    end else if (we && chan == CHAN_ID) begin
      tbl[slot] <= owner;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
      assign owners[g*RW +: RW] = tbl[g];
    end
  endgenerate
endmodule

// File: rtl/slot_chan_arb.sv
module slot_chan_arb #(
  parameter int NUM_REQ   = 8,
  parameter int NUM_SLOTS = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int RW = $clog2(NUM_REQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_REQ-1:0]      req,
  input  logic                    done,
  input  logic [NUM_SLOTS*RW-1:0] owners,
  output logic [NUM_REQ-1:0]      gnt
);
  logic [SW-1:0]      ptr_q, gslot_q;
  logic               busy_q;
  logic [NUM_REQ-1:0] gnt_q;
  logic               hit;
  logic [SW-1:0]      pick_slot;
  logic [RW-1:0]      pick_own;

  // Search one full lap from the pointer for a slot whose owner requests.
  always_comb begin
    hit       = 1'b0;
    pick_slot = ptr_q;
    pick_own  = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      int s;
      logic [RW-1:0] o;
      s = (int'(ptr_q) + k) % NUM_SLOTS;
      o = owners[s*RW +: RW];
      if (!hit && int'(o) < NUM_REQ && req[o]) begin
        hit       = 1'b1;
        pick_slot = SW'(s);
        pick_own  = o;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      gslot_q <= '0;
      gnt_q   <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        gnt_q  <= '0;
        ptr_q  <= SW'((int'(gslot_q) + 1) % NUM_SLOTS);
      end
    end else if (hit) begin
      busy_q  <= 1'b1;
      gslot_q <= pick_slot;
      gnt_q   <= NUM_REQ'(1) << pick_own;
    end
  end

  assign gnt = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|gnt_q && !done) |=> $stable(gnt_q)); // R3
  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (|gnt_q && done) |=> (gnt_q == '0)); // R3

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
      AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_q[i]) |-> $past(req[i])); // R2
    end
  endgenerate
endmodule

// File: rtl/slot_xbar_arb.sv
module slot_xbar_arb #(
  parameter int NUM_REQ   = 8,
  parameter int NUM_SLOTS = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int RW = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] rd_req,
  input  logic [NUM_REQ-1:0] wr_req,
  input  logic               rd_done,
  input  logic               wr_done,
  input  logic               cfg_we,
  input  logic               cfg_chan,
  input  logic [SW-1:0]      cfg_slot,
  input  logic [RW-1:0]      cfg_owner,
  output logic [NUM_REQ-1:0] rd_gnt,
  output logic [NUM_REQ-1:0] wr_gnt
);
  import slotarb_pkg::*;

  logic [NUM_REQ-1:0] req_v [2];
  logic [NUM_REQ-1:0] gnt_v [2];
  logic               done_v [2];

  assign req_v[CH_RD]  = rd_req;
  assign req_v[CH_WR]  = wr_req;
  assign done_v[CH_RD] = rd_done;
  assign done_v[CH_WR] = wr_done;
  assign rd_gnt        = gnt_v[CH_RD];
  assign wr_gnt        = gnt_v[CH_WR];

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chan
      logic [NUM_SLOTS*RW-1:0] owners;

      slot_table #(
        .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .CHAN_ID(c[0])
      ) u_tbl (
        .clk(clk), .rst(rst), .we(cfg_we), .chan(cfg_chan),
        .slot(cfg_slot), .owner(cfg_owner), .owners(owners)
      );

      slot_chan_arb #(
        .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)
      ) u_arb (
        .clk(clk), .rst(rst), .req(req_v[c]), .done(done_v[c]),
        .owners(owners), .gnt(gnt_v[c])
      );
    end
  endgenerate

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (rd_gnt == '0 && wr_gnt == '0)); // R1
endmodule

// File: tb/test_slot_xbar_arb.sv
module test_slot_xbar_arb;
  localparam int NR = 8;
  localparam int NS = 16;

  logic clk = 0;
  logic rst = 1;
  logic [NR-1:0] rd_req = '0, wr_req = '0;
  logic rd_done = 0, wr_done = 0;
  logic cfg_we = 0, cfg_chan = 0;
  logic [3:0] cfg_slot = '0;
  logic [2:0] cfg_owner = '0;
  logic [NR-1:0] rd_gnt, wr_gnt;

  int checks = 0, errors = 0, cycles = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  slot_xbar_arb #(.NUM_REQ(NR), .NUM_SLOTS(NS)) i_slot_xbar_arb (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .rd_done(rd_done), .wr_done(wr_done), .cfg_we(cfg_we),
    .cfg_chan(cfg_chan), .cfg_slot(cfg_slot), .cfg_owner(cfg_owner),
    .rd_gnt(rd_gnt), .wr_gnt(wr_gnt));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference model
  int  mt [2][NS];
  bit  mbusy [2];
  int  mptr [2], mslot [2], mown [2];

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        mbusy[c] = 0; mptr[c] = 0; mslot[c] = 0; mown[c] = 0;
        for (int s = 0; s < NS; s++) mt[c][s] = s % NR;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [NR-1:0] r;
        bit d, found;
        r = c ? wr_req : rd_req;
        d = c ? wr_done : rd_done;
        if (mbusy[c]) begin
          if (d) begin mbusy[c] = 0; mptr[c] = (mslot[c] + 1) % NS; end
        end else begin
          found = 0;
          for (int k = 0; k < NS; k++) begin
            int s;
            s = (mptr[c] + k) % NS;
            if (!found && r[mt[c][s]]) begin
              found = 1; mbusy[c] = 1; mslot[c] = s; mown[c] = mt[c][s];
            end
          end
        end
      end
      if (cfg_we) mt[cfg_chan][cfg_slot] = cfg_owner;
    end
  end

  function automatic int exp_gnt(int c);
    return mbusy[c] ? (1 << mown[c]) : 0;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(rd_gnt == NR'(exp_gnt(0)), "R4 read model", rd_gnt, exp_gnt(0));
      chk(wr_gnt == NR'(exp_gnt(1)), "R6 write model", wr_gnt, exp_gnt(1));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tbl_wr(bit ch, int slot, int own);
    cfg_we = 1; cfg_chan = ch; cfg_slot = 4'(slot); cfg_owner = 3'(own);
    tick(1);
    cfg_we = 0;
  endtask

  function automatic int oh2i(logic [NR-1:0] v);
    for (int i = 0; i < NR; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    tick(3);
    chk(rd_gnt == 0 && wr_gnt == 0, "R1 grants in reset", rd_gnt, 0);
    rst = 0;
    tick(1);
    chk(rd_gnt == 0 && wr_gnt == 0, "R1 grants after reset", rd_gnt, 0);

    // R1/R4: default interleaved table served in order 0..7
    rd_req = '1; rd_done = 1;
    begin
      int n = 0;
      while (n < 8) begin
        tick(1);
        if (rd_gnt != 0) begin
          chk(oh2i(rd_gnt) == n, "R1 default slot order", oh2i(rd_gnt), n);
          n++;
        end
      end
    end
    rd_req = '0; tick(3); rd_done = 0;   // pointer now at slot 8

    // R5: lone requester skips non-requesting slots in one cycle
    rd_req = 8'h08; tick(1);
    chk(rd_gnt == 8'h08, "R5 skip to requester", rd_gnt, 8'h08);

    // R3: grant held with request dropped until done
    rd_req = '0; tick(5);
    chk(rd_gnt == 8'h08, "R3 grant held", rd_gnt, 8'h08);
    rd_done = 1; tick(1); rd_done = 0;
    chk(rd_gnt == 0, "R3 released after done", rd_gnt, 0);

    // R9: done while idle ignored; pointer must still be slot 12
    rd_done = 1; wr_done = 1; tick(3);
    chk(rd_gnt == 0 && wr_gnt == 0, "R9 idle done no grant", rd_gnt, 0);
    rd_done = 0; wr_done = 0;
    rd_req = '1; tick(1);
    chk(rd_gnt == 8'h10, "R9 pointer unchanged", rd_gnt, 8'h10);
    rd_req = '0; rd_done = 1; tick(1); rd_done = 0; tick(1);

    // R6: both channels granted concurrently
    rd_req = 8'h02; wr_req = 8'h40; tick(1);
    chk(rd_gnt == 8'h02, "R6 read concurrent", rd_gnt, 8'h02);
    chk(wr_gnt == 8'h40, "R6 write concurrent", wr_gnt, 8'h40);
    rd_req = '0; wr_req = '0; rd_done = 1; wr_done = 1; tick(1);
    rd_done = 0; wr_done = 0; tick(1);

    // R7: requester 2 loses its read slots; write table untouched (R6)
    tbl_wr(0, 2, 0); tbl_wr(0, 10, 0);
    rd_req = 8'h04; wr_req = 8'h04; tick(1);
    chk(wr_gnt == 8'h04, "R6 write table unaffected", wr_gnt, 8'h04);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        tick(1);
        if (rd_gnt != 0) seen++;
      end
      chk(seen == 0, "R7 slotless never granted", seen, 0);
    end
    rd_req = '0; wr_req = '0; wr_done = 1; tick(1); wr_done = 0; tick(1);

    // R8: table rewritten during a grant
    rd_req = 8'h20; tick(1);
    chk(rd_gnt == 8'h20, "R8 grant before rewrite", rd_gnt, 8'h20);
    for (int s = 0; s < NS; s++) tbl_wr(0, s, 7);
    chk(rd_gnt == 8'h20, "R8 grant kept during rewrite", rd_gnt, 8'h20);
    rd_req = '1; rd_done = 1; tick(1); rd_done = 0; tick(1);
    chk(rd_gnt == 8'h80, "R8 new table used", rd_gnt, 8'h80);
    rd_req = '0; rd_done = 1; tick(1); rd_done = 0; tick(1);

    // R10: share follows slot count (owner 0: 12 slots, owners 1..4: one each)
    for (int s = 0; s < NS; s++) tbl_wr(0, s, (s < 12) ? 0 : s - 11);
    rd_req = '1; rd_done = 1;
    begin
      int n = 0, c0 = 0, c1 = 0;
      while (n < NS) begin
        tick(1);
        if (rd_gnt != 0) begin
          n++;
          if (rd_gnt[0]) c0++;
          if (rd_gnt[1]) c1++;
        end
      end
      chk(c0 == 12, "R10 share owner0", c0, 12);
      chk(c1 == 1, "R10 share owner1", c1, 1);
    end
    rd_req = '0; tick(3); rd_done = 0; tick(2);
    finish_run();
  end
endmodule